// File: doc/BRIEF.md
# Interrupt poll unit

This block sits beside an instruction sequencer and decides, at each instruction boundary, whether the next thing the sequencer runs is an interrupt entry sequence instead of a new instruction. It watches two active-low request lines. The non-maskable line is edge-triggered. Its falling edge is caught on any clock and held until the sequencer acknowledges it. The maskable line is level-triggered and is only looked at in cycles the sequencer marks as poll cycles. It is also gated by an inhibit copy of the interrupt-disable flag.

The sequencer tells the block which cycles are poll cycles and which cycle ends the instruction. An ordinary instruction marks its final cycle as both. A branch marks its operand fetch as a poll cycle, and a taken page-crossing branch also marks its high-byte fixup cycle. A request seen at any poll cycle of the instruction is remembered until the instruction ends. Flag writes come in two kinds. A lagging write suits clear, set and status-pull instructions: the visible flag changes at once, but inhibition follows only after the current poll. An immediate write suits the return-from-interrupt instruction: the new value already governs the poll in the same cycle.

Top module: `intr_poll_unit`

## Requirements
- R1: In reset and straight after it, `takeIntr` and `takeIsNmi` are 0, `iFlag` equals the parameter `RESET_IFLAG` (default 1), and a non-maskable edge latched before reset is discarded.
- R2: A falling edge on `nmiN` is caught on any clock, including a low pulse of a single cycle that lies between poll points, and causes a take at the next instruction end that polls.
- R3: The `irqN` level is ignored in cycles where `pollCycle` is 0. A low level present only in such cycles causes no take.
- R4: `takeIntr` is a one-cycle pulse in the cycle after a cycle with `lastCycle` = 1, and is 1 only when a request was seen at a poll cycle of that instruction.
- R5: Within one instruction, a request seen at any poll cycle is remembered. The take happens at `lastCycle` even if the request has gone by then, and a `lastCycle` without `pollCycle` does not sample new requests.
- R6: When both requests are seen, the type reported is non-maskable (`takeIsNmi` = 1). For a maskable take it is 0.
- R7: A lagging write (`flagWe`=1, `flagImm`=0) leaves the inhibit used by the poll in the same cycle unchanged. The new value governs polls from the next instruction on.
- R8: `iFlag` takes the value of `flagData` in the cycle after any write, whether lagging or immediate.
- R9: An immediate write (`flagWe`=1, `flagImm`=1) sets the inhibit used by the poll in the same cycle.
- R10: `nmiAck` clears the latched non-maskable request, unless a new falling edge arrives in the same cycle, in which case the request stays latched.
- R11: Holding `nmiN` low creates one request only. After it is acknowledged, no further take occurs until `nmiN` rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| nmiN | input | 1 | Non-maskable request, active low, edge triggered |
| irqN | input | 1 | Maskable request, active low, level triggered |
| pollCycle | input | 1 | The current cycle is a poll point |
| lastCycle | input | 1 | The current cycle ends the instruction |
| flagWe | input | 1 | Write the interrupt-disable flag |
| flagImm | input | 1 | 1: inhibit follows the write in this cycle; 0: inhibit lags |
| flagData | input | 1 | Value written to the flag |
| nmiAck | input | 1 | The sequencer has selected the non-maskable vector |
| takeIntr | output | 1 | Pulse: run the interrupt sequence next |
| takeIsNmi | output | 1 | With `takeIntr`: 1 non-maskable, 0 maskable |
| iFlag | output | 1 | Visible interrupt-disable flag, for status pushes |

## Verification
The maskable line is held low while the flag is cleared by a lagging write and, separately, by an immediate write. This separates the one-instruction delay from the same-cycle effect, and a lagging set shows the interrupt still being taken once. Branch-shaped poll patterns are used: not taken, taken without a page cross (with the request present only at the first poll, and only after it), and taken with a cross. These show whether requests are remembered across the instruction and whether non-poll cycles are really ignored. Non-maskable stimuli include a one-cycle pulse, a line held low, an acknowledge in the same cycle as a fresh edge, and both lines active together, which test edge capture, single triggering, the latch clear and priority.

// File: rtl/intr_poll_pkg.sv
`timescale 1ns/1ps
package intr_poll_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic sample;    // poll point in this cycle
    logic boundary;  // last cycle of the instruction
    logic flagLoad;  // write the interrupt-disable flag
    logic flagNow;   // write also governs inhibit in this cycle
    logic flagVal;   // value to write
    logic nmiClear;  // non-maskable request acknowledged
  } pollStrobes_t;

endpackage

// File: rtl/intr_poll_dp.sv
`timescale 1ns/1ps
module intr_poll_dp
  import intr_poll_pkg::*;
#(
  parameter bit RESET_IFLAG = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         nmiN,
  input  logic         irqN,
  input  pollStrobes_t strb,
  output logic         nmiReq,
  output logic         irqReq,
  output logic         iFlag
);

  logic nmiPrev;
  logic nmiPend;
  logic iFlagR;
  logic inhibitR;
  logic nmiFall;
  logic effInhibit;

  // Previous line level, sampled every clock (reset or not) so that an
  // edge is judged against the real prior level.
  always_ff @(posedge clk) begin
    nmiPrev <= nmiN;
  end

  assign nmiFall    = nmiPrev & ~nmiN;
  assign effInhibit = (strb.flagLoad & strb.flagNow) ? strb.flagVal : inhibitR;
  assign irqReq     = ~irqN & ~effInhibit;
  assign nmiReq     = nmiPend;
  assign iFlag      = iFlagR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPend  <= 1'b0;
      iFlagR   <= RESET_IFLAG;
      inhibitR <= RESET_IFLAG;
    end else begin
      // a fresh edge wins over an acknowledge in the same cycle
      nmiPend <= nmiFall | (nmiPend & ~strb.nmiClear);
      if (strb.flagLoad) begin
        iFlagR <= strb.flagVal;
      end
      // inhibit trails the visible flag by one cycle unless written now
      if (strb.flagLoad & strb.flagNow) begin
        inhibitR <= strb.flagVal;
      end else begin
        inhibitR <= iFlagR;
      end
    end
  end

  p_nmi_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiN && $past(nmiN)) |=> nmiPend);

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.nmiClear && !(!nmiN && $past(nmiN))) |=> !nmiPend);

  p_flag_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagLoad |=> (iFlag == $past(strb.flagVal)));

endmodule

// File: rtl/intr_poll_ctrl.sv
`timescale 1ns/1ps
module intr_poll_ctrl
  import intr_poll_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pollCycle,
  input  logic         lastCycle,
  input  logic         flagWe,
  input  logic         flagImm,
  input  logic         flagData,
  input  logic         nmiAck,
  input  logic         nmiReq,
  input  logic         irqReq,
  output pollStrobes_t strb,
  output logic         takeIntr,
  output logic         takeIsNmi
);

  logic caughtNmi;
  logic caughtIrq;
  logic nmiHit;
  logic irqHit;

  always_comb begin
    strb          = '0;
    strb.sample   = pollCycle;
    strb.boundary = lastCycle;
    strb.flagLoad = flagWe;
    strb.flagNow  = flagImm;
    strb.flagVal  = flagData;
    strb.nmiClear = nmiAck;
  end

  assign nmiHit = caughtNmi | (strb.sample & nmiReq);
  assign irqHit = caughtIrq | (strb.sample & irqReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      caughtNmi <= 1'b0;
      caughtIrq <= 1'b0;
      takeIntr  <= 1'b0;
      takeIsNmi <= 1'b0;
    end else if (strb.boundary) begin
      caughtNmi <= 1'b0;
      caughtIrq <= 1'b0;
      takeIntr  <= nmiHit | irqHit;
      takeIsNmi <= nmiHit;
    end else begin
      caughtNmi <= nmiHit;
      caughtIrq <= irqHit;
      takeIntr  <= 1'b0;
      takeIsNmi <= 1'b0;
    end
  end

  p_take_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeIntr |-> $past(lastCycle));

  p_no_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lastCycle && !pollCycle && !caughtNmi && !caughtIrq) |=> !takeIntr);

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastCycle && pollCycle && nmiReq) |=> (takeIntr && takeIsNmi));

  p_type_with_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    takeIsNmi |-> takeIntr);

endmodule

// File: rtl/intr_poll_unit.sv
`timescale 1ns/1ps
module intr_poll_unit
  import intr_poll_pkg::*;
#(
  parameter bit RESET_IFLAG = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic nmiN,
  input  logic irqN,
  input  logic pollCycle,
  input  logic lastCycle,
  input  logic flagWe,
  input  logic flagImm,
  input  logic flagData,
  input  logic nmiAck,
  output logic takeIntr,
  output logic takeIsNmi,
  output logic iFlag
);

  pollStrobes_t strb;
  logic         nmiReq;
  logic         irqReq;

  intr_poll_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pollCycle (pollCycle),
    .lastCycle (lastCycle),
    .flagWe    (flagWe),
    .flagImm   (flagImm),
    .flagData  (flagData),
    .nmiAck    (nmiAck),
    .nmiReq    (nmiReq),
    .irqReq    (irqReq),
    .strb      (strb),
    .takeIntr  (takeIntr),
    .takeIsNmi (takeIsNmi)
  );

  intr_poll_dp #(
    .RESET_IFLAG (RESET_IFLAG)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .nmiN   (nmiN),
    .irqN   (irqN),
    .strb   (strb),
    .nmiReq (nmiReq),
    .irqReq (irqReq),
    .iFlag  (iFlag)
  );

endmodule

// File: tb/sim_intr_poll_unit.sv
`timescale 1ns/1ps
module sim_intr_poll_unit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiN = 1'b1;
  logic irqN = 1'b1;
  logic pollCycle = 1'b0;
  logic lastCycle = 1'b0;
  logic flagWe = 1'b0;
  logic flagImm = 1'b0;
  logic flagData = 1'b0;
  logic nmiAck = 1'b0;
  logic takeIntr;
  logic takeIsNmi;
  logic iFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  intr_poll_unit u0 (
    .clk(clk), .rstN(rstN), .nmiN(nmiN), .irqN(irqN),
    .pollCycle(pollCycle), .lastCycle(lastCycle),
    .flagWe(flagWe), .flagImm(flagImm), .flagData(flagData),
    .nmiAck(nmiAck), .takeIntr(takeIntr), .takeIsNmi(takeIsNmi),
    .iFlag(iFlag)
  );

  // Row: {requirement, inputs n i p l w m d a, expected take nmi flag}
  // inputs: nmiN irqN pollCycle lastCycle flagWe flagImm flagData nmiAck
  // expected values are the outputs after the clock edge of that row.
  localparam int NROWS = 46;
  localparam logic [14:0] VEC [NROWS] = '{
    // R7: irq low, flag set, lagging clear
    {4'd7,  8'b10110000, 3'b001},
    {4'd7,  8'b10000000, 3'b001},
    {4'd7,  8'b10111000, 3'b000},  // clear's own poll still inhibited
    {4'd7,  8'b10000000, 3'b000},
    {4'd7,  8'b10110000, 3'b100},  // taken after one more instruction
    // R9: immediate write
    {4'd9,  8'b11001110, 3'b001},
    {4'd9,  8'b10000000, 3'b001},
    {4'd9,  8'b10111100, 3'b100},  // clear governs this very poll
    {4'd9,  8'b11001110, 3'b001},
    // R8: visible flag follows at once
    {4'd8,  8'b11001100, 3'b000},
    // R7: lagging set still lets one interrupt in
    {4'd7,  8'b10111010, 3'b101},
    {4'd7,  8'b11000000, 3'b001},
    {4'd7,  8'b10110000, 3'b001},
    // R2: one-cycle low pulse on the edge line
    {4'd2,  8'b01000000, 3'b001},
    {4'd2,  8'b11000000, 3'b001},
    {4'd2,  8'b11110000, 3'b111},
    // R10: acknowledge clears
    {4'd10, 8'b11000001, 3'b001},
    {4'd10, 8'b11110000, 3'b001},
    // R11: line held low triggers once
    {4'd11, 8'b01000000, 3'b001},
    {4'd11, 8'b01110000, 3'b111},
    {4'd11, 8'b01000001, 3'b001},
    {4'd11, 8'b01110000, 3'b001},
    {4'd11, 8'b11000000, 3'b001},
    // R8: open the mask
    {4'd8,  8'b11001100, 3'b000},
    // R6: both requests
    {4'd6,  8'b00000000, 3'b000},
    {4'd6,  8'b10110000, 3'b110},
    {4'd6,  8'b11000001, 3'b000},
    // R5: branch not taken
    {4'd5,  8'b11000000, 3'b000},
    {4'd5,  8'b10110000, 3'b100},
    // R5: taken, no cross, request only at the first poll
    {4'd5,  8'b11000000, 3'b000},
    {4'd5,  8'b10100000, 3'b000},
    {4'd5,  8'b11010000, 3'b100},
    // R5 / R3: taken, no cross, request only after the poll
    {4'd5,  8'b11000000, 3'b000},
    {4'd5,  8'b11100000, 3'b000},
    {4'd3,  8'b10010000, 3'b000},
    {4'd3,  8'b11000000, 3'b000},
    // R5: taken with page cross, request at the fixup poll
    {4'd5,  8'b11000000, 3'b000},
    {4'd5,  8'b11100000, 3'b000},
    {4'd5,  8'b11000000, 3'b000},
    {4'd5,  8'b10110000, 3'b100},
    // R10: new edge in the acknowledge cycle keeps the request
    {4'd10, 8'b01000000, 3'b000},
    {4'd10, 8'b11110000, 3'b110},
    {4'd10, 8'b01000001, 3'b000},
    {4'd10, 8'b11110000, 3'b110},
    {4'd10, 8'b11000001, 3'b000},
    {4'd10, 8'b11110000, 3'b000}
  };

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "takeIntr in reset", takeIntr, 1'b0);
    check("R1", "takeIsNmi in reset", takeIsNmi, 1'b0);
    check("R1", "iFlag in reset", iFlag, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "takeIntr after reset", takeIntr, 1'b0);
    check("R1", "iFlag after reset", iFlag, 1'b1);

    // R1: a latched edge is dropped by reset
    nmiN = 1'b0;
    @(negedge clk);
    nmiN = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    pollCycle = 1'b1;
    lastCycle = 1'b1;
    @(negedge clk);
    check("R1", "take after reset with old edge", takeIntr, 1'b0);
    pollCycle = 1'b0;
    lastCycle = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NROWS; k++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[k][14:11], k);
      {nmiN, irqN, pollCycle, lastCycle, flagWe, flagImm, flagData, nmiAck} = VEC[k][10:3];
      @(negedge clk);
      check(tag, "takeIntr", takeIntr, VEC[k][2]);
      check(tag, "takeIsNmi", takeIsNmi, VEC[k][1]);
      check(tag, "iFlag", iFlag, VEC[k][0]);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule